// File: doc/BRIEF.md
# DMA Interrupt Status Aggregator

This block gathers completion and error events from every physical channel of a multi-channel DMA engine and presents them to software as a small register map with one level-sensitive interrupt line. Each channel reports four event classes. The first class is end of chain, which fires when the final node of a linked list finishes. The second is node completion, which fires when a node whose node-interrupt flag is set finishes. The other two are error classes A and B. Every class has its own sticky pending register, its own enable register and a masked view.

A combined status word ORs the four masked views per channel, and the interrupt output ORs that word. Software services an interrupt by reading the status and masked views. It then writes ones to the pending registers to clear the bits it handled. To stop a channel cleanly, software clears the pending bit of that channel in all four classes. Bit i of every register belongs to physical channel i.

Top module: `dma_irq_collect`

## Requirements
- R1: When a channel reports a finished node with the last-node flag, bit i of the end-of-chain pending register (0x600) is set. When it reports a finished node with the node-interrupt flag, bit i of the node pending register (0x608) is set. A node with both flags sets both bits, and a node with neither flag sets nothing.
- R2: A pulse on error input A or error input B of channel i sets bit i of the error-A pending register (0x610) or the error-B pending register (0x618).
- R3: A write to a pending register clears each bit written as 1 and leaves each bit written as 0 unchanged. Pending bits are sticky otherwise. Clearing one register does not affect the others.
- R4: When a new event and a write-1-clear hit the same pending bit in the same cycle, the bit stays set.
- R5: Enable registers sit at 0x018, 0x01C, 0x020 and 0x024 for end-of-chain, node, error A and error B. They read back the value last written and reset to 0. A 0 bit keeps that channel's event away from the masked view, the status word and the interrupt.
- R6: Masked views at 0x004, 0x008, 0x00C and 0x010, in the same class order, read pending AND enable.
- R7: The status word at 0x000 has bit i set exactly when any of the four masked views has bit i set.
- R8: irq_o is high while any status bit is set. After the write that clears the last enabled pending bit, irq_o stays high up to that clock edge and is low right after it.
- R9: Bits at and above the channel count read as zero. Unmapped addresses read zero, and writes to unmapped addresses change nothing.
- R10: After reset, every register reads zero and irq_o is low.
- R11: Clearing bit i in all four pending registers removes every pending event of channel i and leaves the other channels' pending bits untouched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| node_done | input | NUM_CH | Per-channel pulse: a linked-list node finished |
| node_last | input | NUM_CH | Qualifies node_done: that node ended the chain |
| node_irq | input | NUM_CH | Qualifies node_done: that node has its node-interrupt flag set |
| err_a | input | NUM_CH | Per-channel error pulse, class A |
| err_b | input | NUM_CH | Per-channel error pulse, class B |
| wr_en | input | 1 | Register write strobe |
| addr | input | ADDR_W | Register byte address |
| wdata | input | DATA_W | Register write data |
| rdata | output | DATA_W | Read data for addr, combinational |
| irq_o | output | 1 | Level-sensitive interrupt request |

## Verification
On every cycle, the assertions check the following. Pending bits hold unless an event or a clear hits them. An event bit always lands even against a clear. A clear removes every written bit that was not being set at the same time. Enable registers change only when written. irq_o never rises without both a pending bit and an enable bit, and the upper read bits stay zero. Only the bench scenarios can show the finer points. These are the mapping of node flags to the right class, the exact masked and status values across enable patterns, the cycle where irq_o drops after the final clear, the stop sequence that preserves other channels, and the inertness of unmapped addresses.

// File: rtl/dma_irq_pkg.sv
`timescale 1ns/1ps
package dma_irq_pkg;

  localparam int NCLS = 4;

  typedef enum logic [1:0] {
    CLS_END  = 2'd0,
    CLS_NODE = 2'd1,
    CLS_ERRA = 2'd2,
    CLS_ERRB = 2'd3
  } irq_cls_e;

  localparam logic [11:0] OFF_STATUS = 12'h000;
  localparam logic [11:0] OFF_MSKD   = 12'h004;
  localparam logic [11:0] OFF_EN     = 12'h018;
  localparam logic [11:0] OFF_RAW    = 12'h600;

  localparam int STRIDE_MSKD = 4;
  localparam int STRIDE_EN   = 4;
  localparam int STRIDE_RAW  = 8;

  function automatic logic [11:0] mskd_off(input int k);
    return OFF_MSKD + 12'(STRIDE_MSKD * k);
  endfunction

  function automatic logic [11:0] en_off(input int k);
    return OFF_EN + 12'(STRIDE_EN * k);
  endfunction

  function automatic logic [11:0] raw_off(input int k);
    return OFF_RAW + 12'(STRIDE_RAW * k);
  endfunction

endpackage

// File: rtl/dma_irq_evt_map.sv
`timescale 1ns/1ps
module dma_irq_evt_map
  import dma_irq_pkg::*;
#(
  parameter int NUM_CH = 16
) (
  input  logic [NUM_CH-1:0]           node_done,
  input  logic [NUM_CH-1:0]           node_last,
  input  logic [NUM_CH-1:0]           node_irq,
  input  logic [NUM_CH-1:0]           err_a,
  input  logic [NUM_CH-1:0]           err_b,
  output logic [NCLS-1:0][NUM_CH-1:0] set_vec
);

  always_comb begin
    set_vec           = '0;
    set_vec[CLS_END]  = node_done & node_last;
    set_vec[CLS_NODE] = node_done & node_irq;
    set_vec[CLS_ERRA] = err_a;
    set_vec[CLS_ERRB] = err_b;
  end

endmodule

// File: rtl/dma_irq_pend_bank.sv
`timescale 1ns/1ps
module dma_irq_pend_bank #(
  parameter int NUM_CH = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] set_i,
  input  logic              clr_we,
  input  logic              en_we,
  input  logic [NUM_CH-1:0] wbits,
  output logic [NUM_CH-1:0] raw_o,
  output logic [NUM_CH-1:0] en_o,
  output logic [NUM_CH-1:0] masked_o
);

  logic [NUM_CH-1:0] raw_q, raw_d;
  logic [NUM_CH-1:0] en_q, en_d;
  logic              raw_ce, en_ce;

  // Next state: clear first, then new events override the clear.
  always_comb begin
    raw_d = raw_q;
    if (clr_we) raw_d = raw_q & ~wbits;
    raw_d  = raw_d | set_i;
    raw_ce = clr_we | (|set_i);
    en_d   = wbits;
    en_ce  = en_we;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      raw_q <= '0;
      en_q  <= '0;
    end else begin
      if (raw_ce) raw_q <= raw_d;
      if (en_ce)  en_q  <= en_d;
    end
  end

  assign raw_o    = raw_q;
  assign en_o     = en_q;
  assign masked_o = raw_q & en_q;

endmodule

// File: rtl/dma_irq_regmap.sv
`timescale 1ns/1ps
module dma_irq_regmap
  import dma_irq_pkg::*;
#(
  parameter int NUM_CH = 16,
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32
) (
  input  logic                       wr_en,
  input  logic [ADDR_W-1:0]          addr,
  input  logic [NUM_CH-1:0]          status,
  input  logic [NCLS-1:0][NUM_CH-1:0] masked_vec,
  input  logic [NCLS-1:0][NUM_CH-1:0] en_vec,
  input  logic [NCLS-1:0][NUM_CH-1:0] raw_vec,
  output logic [NCLS-1:0]            clr_we,
  output logic [NCLS-1:0]            en_we,
  output logic [DATA_W-1:0]          rdata
);

  logic [NUM_CH-1:0] sel;

  always_comb begin
    clr_we = '0;
    en_we  = '0;
    for (int k = 0; k < NCLS; k++) begin
      clr_we[k] = wr_en && (addr == ADDR_W'(raw_off(k)));
      en_we[k]  = wr_en && (addr == ADDR_W'(en_off(k)));
    end
  end

  always_comb begin
    sel = '0;
    if (addr == ADDR_W'(OFF_STATUS)) sel = status;
    for (int k = 0; k < NCLS; k++) begin
      if (addr == ADDR_W'(mskd_off(k))) sel = masked_vec[k];
      if (addr == ADDR_W'(en_off(k)))   sel = en_vec[k];
      if (addr == ADDR_W'(raw_off(k)))  sel = raw_vec[k];
    end
    rdata = DATA_W'(sel);
  end

endmodule

// File: rtl/dma_irq_collect.sv
`timescale 1ns/1ps
module dma_irq_collect
  import dma_irq_pkg::*;
#(
  parameter int NUM_CH = 16,
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] node_done,
  input  logic [NUM_CH-1:0] node_last,
  input  logic [NUM_CH-1:0] node_irq,
  input  logic [NUM_CH-1:0] err_a,
  input  logic [NUM_CH-1:0] err_b,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              irq_o
);

  localparam int HI_W = DATA_W - NUM_CH;

  logic [1:0]                  rst_sync;
  logic                        rst_q_n;
  logic [NCLS-1:0][NUM_CH-1:0] set_vec;
  logic [NCLS-1:0][NUM_CH-1:0] raw_vec;
  logic [NCLS-1:0][NUM_CH-1:0] en_vec;
  logic [NCLS-1:0][NUM_CH-1:0] masked_vec;
  logic [NCLS-1:0]             clr_we;
  logic [NCLS-1:0]             en_we;
  logic [NUM_CH-1:0]           status;

  // Reset asserts at once and releases two edges later.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_q_n = rst_sync[1];

  dma_irq_evt_map #(.NUM_CH(NUM_CH)) u_evt (
    .node_done (node_done),
    .node_last (node_last),
    .node_irq  (node_irq),
    .err_a     (err_a),
    .err_b     (err_b),
    .set_vec   (set_vec)
  );

  for (genvar k = 0; k < NCLS; k++) begin : g_bank
    dma_irq_pend_bank #(.NUM_CH(NUM_CH)) u_bank (
      .clk      (clk),
      .rst_n    (rst_q_n),
      .set_i    (set_vec[k]),
      .clr_we   (clr_we[k]),
      .en_we    (en_we[k]),
      .wbits    (wdata[NUM_CH-1:0]),
      .raw_o    (raw_vec[k]),
      .en_o     (en_vec[k]),
      .masked_o (masked_vec[k])
    );
  end

  if (HI_W > 0) begin : g_hi
    logic unused_wr_hi;
    assign unused_wr_hi = ^wdata[DATA_W-1:NUM_CH];
  end

  always_comb begin
    status = '0;
    for (int k = 0; k < NCLS; k++) status = status | masked_vec[k];
  end

  assign irq_o = |status;

  dma_irq_regmap #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_map (
    .wr_en      (wr_en),
    .addr       (addr),
    .status     (status),
    .masked_vec (masked_vec),
    .en_vec     (en_vec),
    .raw_vec    (raw_vec),
    .clr_we     (clr_we),
    .en_we      (en_we),
    .rdata      (rdata)
  );

endmodule

// File: rtl/dma_irq_collect_chk.sv
`timescale 1ns/1ps
module dma_irq_collect_chk
  import dma_irq_pkg::*;
#(
  parameter int NUM_CH = 16,
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        wr_en,
  input logic [ADDR_W-1:0]           addr,
  input logic [NUM_CH-1:0]           wbits,
  input logic [NCLS-1:0][NUM_CH-1:0] set_vec,
  input logic [NCLS-1:0][NUM_CH-1:0] raw_vec,
  input logic [NCLS-1:0][NUM_CH-1:0] en_vec,
  input logic                        irq_o,
  input logic [DATA_W-1:0]           rdata
);

  for (genvar k = 0; k < NCLS; k++) begin : g_cls
    AST_SET_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
      (|set_vec[k]) |=> ((raw_vec[k] & $past(set_vec[k])) == $past(set_vec[k]))); // R4
    AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == ADDR_W'(raw_off(k))) |=> ((raw_vec[k] & $past(wbits & ~set_vec[k])) == '0)); // R3
    AST_RAW_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (!(wr_en && addr == ADDR_W'(raw_off(k))) && (set_vec[k] == '0)) |=> $stable(raw_vec[k])); // R3
    AST_EN_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en && addr == ADDR_W'(en_off(k))) |=> $stable(en_vec[k])); // R5
    AST_EN_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == ADDR_W'(en_off(k))) |=> (en_vec[k] == $past(wbits))); // R5
  end

  AST_IRQ_NEEDS_RAW: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (|raw_vec)); // R8
  AST_IRQ_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (|en_vec)); // R5

  if (DATA_W > NUM_CH) begin : g_upper
    AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      rdata[DATA_W-1:NUM_CH] == '0); // R9
  end

endmodule

bind dma_irq_collect dma_irq_collect_chk #(
  .NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
) u_chk (
  .clk     (clk),
  .rst_n   (rst_q_n),
  .wr_en   (wr_en),
  .addr    (addr),
  .wbits   (wdata[NUM_CH-1:0]),
  .set_vec (set_vec),
  .raw_vec (raw_vec),
  .en_vec  (en_vec),
  .irq_o   (irq_o),
  .rdata   (rdata)
);

// File: tb/dma_irq_collect_test.sv
`timescale 1ns/1ps
module dma_irq_collect_test;

  localparam int NCH = 16;
  localparam int AW  = 12;
  localparam int DW  = 32;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [NCH-1:0] node_done, node_last, node_irq, err_a, err_b;
  logic          wr_en;
  logic [AW-1:0] addr;
  logic [DW-1:0] wdata;
  logic [DW-1:0] rdata;
  logic          irq_o;

  int n_cmp = 0;
  int n_bad = 0;
  logic [NCH-1:0] m_raw [4];
  logic [NCH-1:0] m_en  [4];

  always #2.5 clk = ~clk;

  dma_irq_collect #(.NUM_CH(NCH), .ADDR_W(AW), .DATA_W(DW)) uut (
    .clk(clk), .rst_n(rst_n),
    .node_done(node_done), .node_last(node_last), .node_irq(node_irq),
    .err_a(err_a), .err_b(err_b),
    .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .irq_o(irq_o)
  );

  function automatic logic [AW-1:0] a_raw(input int k);  return AW'(12'h600 + 8*k); endfunction
  function automatic logic [AW-1:0] a_en(input int k);   return AW'(12'h018 + 4*k); endfunction
  function automatic logic [AW-1:0] a_mskd(input int k); return AW'(12'h004 + 4*k); endfunction

  function automatic logic [NCH-1:0] exp_status();
    logic [NCH-1:0] s = '0;
    for (int k = 0; k < 4; k++) s = s | (m_raw[k] & m_en[k]);
    return s;
  endfunction

  task automatic chk(input string req, input string what, input logic [DW-1:0] got, input logic [DW-1:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, got, exp);
    end
  endtask

  // One register write and/or event pulse, applied on a single clock edge.
  task automatic step(input logic wr, input logic [AW-1:0] a, input logic [DW-1:0] wd,
                      input logic [NCH-1:0] dn, input logic [NCH-1:0] ls, input logic [NCH-1:0] ni,
                      input logic [NCH-1:0] ea, input logic [NCH-1:0] eb);
    @(negedge clk);
    wr_en = wr; addr = a; wdata = wd;
    node_done = dn; node_last = ls; node_irq = ni; err_a = ea; err_b = eb;
    for (int k = 0; k < 4; k++) begin
      if (wr && a == a_raw(k)) m_raw[k] = m_raw[k] & ~wd[NCH-1:0];
      if (wr && a == a_en(k))  m_en[k]  = wd[NCH-1:0];
    end
    m_raw[0] = m_raw[0] | (dn & ls);
    m_raw[1] = m_raw[1] | (dn & ni);
    m_raw[2] = m_raw[2] | ea;
    m_raw[3] = m_raw[3] | eb;
    @(negedge clk);
    wr_en = 1'b0; node_done = '0; node_last = '0; node_irq = '0; err_a = '0; err_b = '0;
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] wd);
    step(1'b1, a, wd, '0, '0, '0, '0, '0);
  endtask

  task automatic rd_chk(input string req, input logic [AW-1:0] a, input logic [DW-1:0] exp);
    @(negedge clk);
    addr = a;
    #1;
    chk(req, $sformatf("read %h", a), rdata, exp);
  endtask

  task automatic check_all(input string req);
    for (int k = 0; k < 4; k++) begin
      rd_chk(req, a_raw(k),  DW'(m_raw[k]));
      rd_chk(req, a_en(k),   DW'(m_en[k]));
      rd_chk(req, a_mskd(k), DW'(m_raw[k] & m_en[k]));
    end
    rd_chk(req, 12'h000, DW'(exp_status()));
    chk(req, "irq_o", DW'(irq_o), DW'(|exp_status()));
  endtask

  task automatic t_reset;
    check_all("R10");
  endtask

  task automatic t_node_events;
    // ch3 last only, ch5 node-irq only, ch7 neither, ch9 both
    step(1'b0, '0, '0, 16'h02A8, 16'h0208, 16'h0220, '0, '0);
    rd_chk("R1", 12'h600, 32'h0000_0208);
    rd_chk("R1", 12'h608, 32'h0000_0220);
    check_all("R1");
  endtask

  task automatic t_errors;
    step(1'b0, '0, '0, '0, '0, '0, 16'h0001, 16'h8000);
    rd_chk("R2", 12'h610, 32'h0000_0001);
    rd_chk("R2", 12'h618, 32'h0000_8000);
    chk("R5", "irq with all enables 0", DW'(irq_o), 32'h0);
    check_all("R2");
  endtask

  task automatic t_masking;
    wr(12'h01C, 32'h0000_0020);
    rd_chk("R6", 12'h008, 32'h0000_0020);
    rd_chk("R6", 12'h004, 32'h0000_0000);
    rd_chk("R7", 12'h000, 32'h0000_0020);
    chk("R8", "irq with one enabled bit", DW'(irq_o), 32'h1);
    for (int k = 0; k < 4; k++) wr(a_en(k), 32'h0000_FFFF);
    rd_chk("R7", 12'h000, 32'h0000_8229);
    check_all("R6");
  endtask

  task automatic t_w1c;
    wr(12'h600, 32'h0000_0008);
    rd_chk("R3", 12'h600, 32'h0000_0200);
    wr(12'h608, 32'h0000_0000);
    rd_chk("R3", 12'h608, 32'h0000_0220);
    check_all("R3");
  endtask

  task automatic t_collision;
    step(1'b1, 12'h600, 32'h0000_0200, 16'h0200, 16'h0200, '0, '0, '0);
    rd_chk("R4", 12'h600, 32'h0000_0200);
  endtask

  task automatic t_stop;
    for (int k = 0; k < 4; k++) wr(a_raw(k), 32'h0000_0200);
    rd_chk("R11", 12'h600, 32'h0000_0000);
    rd_chk("R11", 12'h608, 32'h0000_0020);
    rd_chk("R11", 12'h610, 32'h0000_0001);
    rd_chk("R11", 12'h618, 32'h0000_8000);
    check_all("R11");
  endtask

  task automatic t_irq_drop;
    wr(12'h608, 32'h0000_0020);
    wr(12'h610, 32'h0000_0001);
    @(negedge clk);
    wr_en = 1'b1; addr = 12'h618; wdata = 32'h0000_8000;
    #1;
    chk("R8", "irq before final clear edge", DW'(irq_o), 32'h1);
    m_raw[3] = '0;
    @(negedge clk);
    wr_en = 1'b0;
    chk("R8", "irq after final clear edge", DW'(irq_o), 32'h0);
    check_all("R8");
  endtask

  task automatic t_unmapped;
    step(1'b0, '0, '0, '0, '0, '0, 16'h0002, '0);
    wr(12'h604, 32'hFFFF_FFFF);
    wr(12'h014, 32'hFFFF_FFFF);
    wr(12'h700, 32'hFFFF_FFFF);
    rd_chk("R9", 12'h610, 32'h0000_0002);
    rd_chk("R9", 12'h014, 32'h0000_0000);
    rd_chk("R9", 12'h700, 32'h0000_0000);
    wr(12'h018, 32'hFFFF_FFFF);
    rd_chk("R9", 12'h018, 32'h0000_FFFF);
    check_all("R9");
  endtask

  initial begin
    #(200000 * 5);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog (all requirements): actual still running expected finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; addr = '0; wdata = '0;
    node_done = '0; node_last = '0; node_irq = '0; err_a = '0; err_b = '0;
    for (int k = 0; k < 4; k++) begin m_raw[k] = '0; m_en[k] = '0; end
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_node_events();
    t_errors();
    t_masking();
    t_w1c();
    t_collision();
    t_stop();
    t_irq_drop();
    t_unmapped();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule